// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point numbers (1 sign bit at the top, then 8 biased exponent bits, then 23 fraction bits at the bottom) and returns their 32-bit product. It handles the three fields separately. The product sign is the exclusive-or of the operand signs. The product exponent starts as the sum of the two biased exponents with one bias of 127 removed. The significand product is a 24 by 24 integer multiply of the two significands, each with its hidden leading one restored. The block then normalizes that product, rounds it to nearest with ties to even, and corrects the exponent after rounding. Results that leave the normal range become a signed infinity or a signed zero, and a flag reports which.

Operands enter through a valid/ready handshake and results leave through one. An operand pair is accepted in any cycle where `in_valid` and `in_ready` are both high. When `OUT_REG` is 1 (the default), the block holds one result in an output register. `in_ready` is high whenever that register is empty or is being emptied in the same cycle by `out_ready`, so a stalled consumer stalls the producer without losing or duplicating a result. When `OUT_REG` is 0 the datapath is purely combinational: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.

Subnormal operands are treated as zero. Every NaN result is the single canonical quiet pattern 0x7FC00000.

Top module: `fp32_mul`

## Requirements
- R1: The sign of every non-NaN result (bit 31) is the exclusive-or of bit 31 of the two accepted operands.
- R2: For normal operands whose significand product lies in [1,2) and needs no rounding increment, the result exponent field is ea+eb-127 and the fraction is the upper 23 fraction bits of the product.
- R3: When the significand product is 2 or more (bit 47 of the 48-bit product set), it is shifted right by one and the exponent is raised by one before rounding.
- R4: The significand is rounded to 24 bits by round-to-nearest, ties-to-even, using every discarded product bit.
- R5: A carry out of the rounding increment renormalizes the significand to 1.0 and raises the exponent by one more.
- R6: If the final exponent is 255 or more, the result is a signed infinity (exponent field all ones, fraction zero) with `out_ovf`=1 and `out_unf`=0.
- R7: If the final exponent is 0 or less, the result is a signed zero with `out_unf`=1 and `out_ovf`=0.
- R8: If either operand has exponent field 0 (zero or subnormal) and neither has exponent field 255, the result is a signed zero and both flags are 0.
- R9: A NaN operand (exponent 255, fraction non-zero), or infinity times an operand with exponent field 0, gives 0x7FC00000. Infinity times any other non-NaN operand gives a signed infinity. Both flags are 0 in these cases.
- R10: With `OUT_REG`=1, the result of an accepted pair is presented with `out_valid` high in the next cycle. It is held unchanged while `out_ready` is low, and `in_ready` equals (not `out_valid`) or `out_ready`.
- R11: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can accept an operand pair this cycle |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Product |
| out_ovf | output | 1 | Result overflowed to infinity |
| out_unf | output | 1 | Result underflowed to zero |

## Verification
With the default output register, a pair accepted at one rising edge produces its result, flags and `out_valid` right after that edge. The result then stays on the outputs until the edge at which `out_ready` is high. `in_ready` responds combinationally to `out_ready` within the same cycle. The bench keeps a one-entry model of the output stage that it advances at each rising edge. It compares `out_valid`, the result and the flags against that model on every falling edge, and compares `in_ready` a moment after it drives new inputs. Random back-pressure holds results for several cycles, so the hold behaviour is checked against the same model.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
package fpm_pkg;
  typedef enum logic [1:0] {
    FCL_ZERO = 2'd0,
    FCL_NORM = 2'd1,
    FCL_INF  = 2'd2,
    FCL_NAN  = 2'd3
  } fcl_e;
endpackage

// File: rtl/fpm_unpack.sv
`timescale 1ns/1ps
module fpm_unpack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0]      op,
  output logic              sgn,
  output logic [EXP_W-1:0]  bexp,
  output logic [FRAC_W:0]   sig,
  output fpm_pkg::fcl_e     cls
);
  logic [FRAC_W-1:0] frac;

  assign sgn  = op[W-1];
  assign bexp = op[W-2 -: EXP_W];
  assign frac = op[FRAC_W-1:0];
  assign sig  = {1'b1, frac};

  always_comb begin
    if (&bexp)       cls = (|frac) ? fpm_pkg::FCL_NAN : fpm_pkg::FCL_INF;
    else if (~|bexp) cls = fpm_pkg::FCL_ZERO;
    else             cls = fpm_pkg::FCL_NORM;
  end
endmodule

// File: rtl/fpm_norm_round.sv
`timescale 1ns/1ps
module fpm_norm_round #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int M  = FRAC_W + 1,
  localparam int PW = 2 * M,
  localparam int XW = EXP_W + 2
) (
  input  logic [M-1:0]          sig_a,
  input  logic [M-1:0]          sig_b,
  input  logic signed [XW-1:0]  exp_in,
  output logic [FRAC_W-1:0]     frac_out,
  output logic signed [XW-1:0]  exp_out
);
  logic [PW-1:0]        prod;
  logic                 hi;
  logic [M-1:0]         mant;
  logic                 g_bit, r_bit, s_bit, inc;
  logic [M:0]           rsum;
  logic                 cy;
  logic signed [XW-1:0] bump;

  assign prod = PW'(sig_a) * PW'(sig_b);
  assign hi   = prod[PW-1];

  always_comb begin
    if (hi) begin
      mant  = prod[PW-1 -: M];
      g_bit = prod[M-1];
      r_bit = prod[M-2];
      s_bit = |prod[M-3:0];
    end else begin
      mant  = prod[PW-2 -: M];
      g_bit = prod[M-2];
      r_bit = prod[M-3];
      s_bit = |prod[M-4:0];
    end
  end

  assign inc      = g_bit & (r_bit | s_bit | mant[0]);
  assign rsum     = {1'b0, mant} + (M+1)'(inc);
  assign cy       = rsum[M];
  assign frac_out = cy ? '0 : rsum[FRAC_W-1:0];
  assign bump     = XW'(hi) + XW'(cy);
  assign exp_out  = exp_in + bump;
endmodule

// File: rtl/fp32_mul.sv
`timescale 1ns/1ps
module fp32_mul #(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter bit OUT_REG = 1'b1,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_ovf,
  output logic         out_unf
);
  import fpm_pkg::*;

  localparam int XW = EXP_W + 2;
  localparam logic signed [XW-1:0] BIAS = XW'(2**(EXP_W-1) - 1);
  localparam logic signed [XW-1:0] EMAX = XW'(2**EXP_W - 1);
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [W-1:0]      opnd [2];
  logic              sgn  [2];
  logic [EXP_W-1:0]  bexp [2];
  logic [FRAC_W:0]   sig  [2];
  fcl_e              cls  [2];

  assign opnd[0] = in_a;
  assign opnd[1] = in_b;

  for (genvar i = 0; i < 2; i++) begin : g_unp
    fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp (
      .op(opnd[i]), .sgn(sgn[i]), .bexp(bexp[i]), .sig(sig[i]), .cls(cls[i])
    );
  end

  logic signed [XW-1:0] ea_s, eb_s, esum, efin;
  logic [FRAC_W-1:0]    frac_r;

  assign ea_s = XW'(bexp[0]);
  assign eb_s = XW'(bexp[1]);
  assign esum = ea_s + eb_s - BIAS;

  fpm_norm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nr (
    .sig_a(sig[0]), .sig_b(sig[1]), .exp_in(esum),
    .frac_out(frac_r), .exp_out(efin)
  );

  logic         psgn;
  logic [W-1:0] c_res;
  logic         c_ovf, c_unf;
  logic         any_nan, any_inf, any_zero;

  assign psgn     = sgn[0] ^ sgn[1];
  assign any_nan  = (cls[0] == FCL_NAN)  || (cls[1] == FCL_NAN);
  assign any_inf  = (cls[0] == FCL_INF)  || (cls[1] == FCL_INF);
  assign any_zero = (cls[0] == FCL_ZERO) || (cls[1] == FCL_ZERO);

  always_comb begin
    c_ovf = 1'b0;
    c_unf = 1'b0;
    if (any_nan || (any_inf && any_zero)) begin
      c_res = QNAN;
    end else if (any_inf) begin
      c_res = {psgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (any_zero) begin
      c_res = {psgn, {(W-1){1'b0}}};
    end else if (efin >= EMAX) begin
      c_res = {psgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      c_ovf = 1'b1;
    end else if (efin <= 0) begin
      c_res = {psgn, {(W-1){1'b0}}};
      c_unf = 1'b1;
    end else begin
      c_res = {psgn, efin[EXP_W-1:0], frac_r};
    end
  end

  if (OUT_REG) begin : g_reg
    assign in_ready = !out_valid || out_ready;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_valid  <= 1'b0;
        out_result <= '0;
        out_ovf    <= 1'b0;
        out_unf    <= 1'b0;
      end else if (in_ready) begin
        out_valid <= in_valid;
        if (in_valid) begin
          out_result <= c_res;
          out_ovf    <= c_ovf;
          out_unf    <= c_unf;
        end
      end
    end
  end else begin : g_comb
    assign in_ready   = out_ready;
    assign out_valid  = in_valid;
    assign out_result = c_res;
    assign out_ovf    = c_ovf;
    assign out_unf    = c_unf;
  end
endmodule

// File: rtl/fp32_mul_chk.sv
`timescale 1ns/1ps
module fp32_mul_chk #(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter bit OUT_REG = 1'b1,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_result,
  input logic         out_ovf,
  input logic         out_unf
);
  logic res_nan;
  assign res_nan = (&out_result[W-2 -: EXP_W]) && (|out_result[FRAC_W-1:0]);

  // R6
  ovf_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ovf |-> out_result[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}});

  // R7
  unf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unf |-> out_result[W-2:0] == '0);

  // R6
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_ovf && out_unf));

  // R11
  always @(posedge clk) begin
    if (!rst_n) reset_idle_chk: assert (!out_valid && in_ready);
  end

  if (OUT_REG) begin : g_seq
    // R10
    accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_ovf) && $stable(out_unf));

    // R1
    sign_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> res_nan || (out_result[W-1] == $past(in_a[W-1] ^ in_b[W-1])));
  end
endmodule

bind fp32_mul fp32_mul_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .OUT_REG(OUT_REG)) u_fp32_mul_chk (.*);

// File: tb/test_fp32_mul.sv
`timescale 1ns/1ps
module test_fp32_mul;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_result;
  logic        out_ovf, out_unf;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model state of the output stage
  bit          m_valid = 0;
  logic [31:0] m_res = '0;
  bit          m_ovf = 0, m_unf = 0;
  string       m_tag = "R2";

  always #2.5 clk = ~clk;

  fp32_mul i_fp32_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_ovf(out_ovf), .out_unf(out_unf)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: exact integer product, rounded to nearest-even.
  task automatic ref_mul(input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] r, output bit ov, output bit un, output string tag);
    int ea = a[30:23], eb = b[30:23];
    bit sa = a[31], sb = b[31], s;
    bit na = (ea == 255) && (a[22:0] != 0);
    bit nb = (eb == 255) && (b[22:0] != 0);
    longint unsigned p, q, rem, half;
    int sh, e;
    s = sa ^ sb; ov = 0; un = 0;
    if (na || nb || (ea == 255 && eb == 0) || (eb == 255 && ea == 0)) begin
      r = 32'h7FC0_0000; tag = "R9";
    end else if (ea == 255 || eb == 255) begin
      r = {s, 8'hFF, 23'd0}; tag = "R9";
    end else if (ea == 0 || eb == 0) begin
      r = {s, 31'd0}; tag = "R8";
    end else begin
      p = longint'({1'b1, a[22:0]}) * longint'({1'b1, b[22:0]});
      sh = (p >= (64'd1 << 47)) ? 24 : 23;
      e = ea + eb - 127 + (sh - 23);
      tag = (sh == 24) ? "R3" : "R2";
      q = p >> sh;
      rem = p - (q << sh);
      half = 64'd1 << (sh - 1);
      if (rem > half || (rem == half && q[0])) begin
        q = q + 1;
        tag = "R4";
      end
      if (q == (64'd1 << 24)) begin
        q = 64'd1 << 23;
        e = e + 1;
        tag = "R5";
      end
      if (e >= 255) begin
        r = {s, 8'hFF, 23'd0}; ov = 1; tag = "R6";
      end else if (e <= 0) begin
        r = {s, 31'd0}; un = 1; tag = "R7";
      end else begin
        r = {s, e[7:0], q[22:0]};
      end
    end
  endtask

  // One clock cycle: compare outputs to model, drive inputs, advance model.
  task automatic step(input bit av, input logic [31:0] a, input logic [31:0] b,
                      input bit rdy, output bit took);
    logic [31:0] r; bit ov, un; string tg;
    chk(out_valid === m_valid, "R10", {31'd0, out_valid}, {31'd0, m_valid});
    if (m_valid) begin
      if (m_res != 32'h7FC0_0000)
        chk(out_result[31] === m_res[31], "R1", out_result, m_res);
      chk(out_result === m_res, m_tag, out_result, m_res);
      chk({out_ovf, out_unf} === {m_ovf, m_unf}, m_tag, {30'd0, out_ovf, out_unf}, {30'd0, m_ovf, m_unf});
    end
    in_valid = av; in_a = a; in_b = b; out_ready = rdy;
    #1;
    chk(in_ready === (!m_valid || rdy), "R10", {31'd0, in_ready}, {31'd0, (!m_valid || rdy)});
    took = av && (!m_valid || rdy);
    if (!m_valid || rdy) m_valid = av;
    if (took) begin
      ref_mul(a, b, r, ov, un, tg);
      m_res = r; m_ovf = ov; m_unf = un; m_tag = tg;
    end
    @(negedge clk);
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] b);
    bit took;
    do step(1'b1, a, b, ($urandom % 4) != 0, took); while (!took);
    if (($urandom % 3) == 0) step(1'b0, '0, '0, ($urandom % 2) != 0, took);
  endtask

  logic [31:0] va [26] = '{
    32'h3F80_0000, 32'h3FC0_0000, 32'h4040_0000, 32'h3F80_0001, 32'h3F80_0003,
    32'h3FB5_04F3, 32'h3FFF_FFFF, 32'h7F00_0000, 32'h0080_0000, 32'h0000_0000,
    32'h8000_0000, 32'h0000_0001, 32'h7F80_0000, 32'h7F80_0000, 32'h7FC1_2345,
    32'h7F00_0000, 32'hFF80_0000, 32'h3F80_0001, 32'h1F80_0000, 32'h3FFF_FFFF,
    32'h4000_0000, 32'hC0A0_0000, 32'h7F7F_FFFF, 32'h00FF_FFFF, 32'h3F00_0000,
    32'h3F7F_FFFF };
  logic [31:0] vb [26] = '{
    32'h3F80_0000, 32'h3FC0_0000, 32'hC000_0000, 32'h3FC0_0000, 32'h3FC0_0000,
    32'h3FB5_04F3, 32'h3F80_0001, 32'h4000_0000, 32'h3F00_0000, 32'h40A0_0000,
    32'h4040_0000, 32'h3F80_0000, 32'h4000_0000, 32'h0000_0000, 32'h3F80_0000,
    32'h3FFF_FFFF, 32'h8000_0005, 32'h3F80_0001, 32'h2000_0000, 32'h3FFF_FFFF,
    32'hC000_0000, 32'hBF80_0000, 32'h7F7F_FFFF, 32'h3F7F_FFFF, 32'h7F80_0001,
    32'h3F80_0001 };

  initial begin
    bit took;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(out_valid === 1'b0, "R11", {31'd0, out_valid}, 32'd0);
    chk(in_ready === 1'b1, "R11", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners: R2..R9
    for (int i = 0; i < 26; i++) send(va[i], vb[i]);
    // R10: long stall on a held result
    step(1'b1, 32'h4010_0000, 32'h4010_0000, 1'b1, took);
    for (int i = 0; i < 6; i++) step(1'b1, 32'h3F80_0000, 32'h4000_0000, 1'b0, took);
    // random operands, mixed exponent ranges
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      if ((n % 4) != 0) begin
        a[30:23] = 8'(64 + ($urandom % 128));
        b[30:23] = 8'(64 + ($urandom % 128));
      end
      send(a, b);
    end
    for (int i = 0; i < 4; i++) step(1'b0, '0, '0, 1'b1, took);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL R10 watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule